// File: doc/BRIEF.md
# Register Preload and Security Lock Controller

This block is the test and programming access port of a small programmable logic device. It owns the bank of output registers and gives test equipment a way to force any one of them to a chosen level, regardless of what the logic array presents. It also lets a programmer write and verify the configuration fuse array, and keep a short user signature of eight bytes. The fuse array and the signature are modelled as synchronous-read memories.

A single security bit protects the design stored in the fuses. Once it is set, every later fuse program, fuse verify and register preload is refused. A refused command still completes, but it reports an error and returns zero data. The signature stays readable and writable whatever the lock state. The only way to clear the lock is a full erase. A full erase walks the whole fuse array one word per cycle, zeroing it, and leaves the signature untouched.

Commands use a valid/busy port. A command is taken only while `busy` is low, and it always finishes with a one-cycle `ack` carrying `err` and `rdata`. Synchronous reset models power-up of a blank device: the lock is clear and all output registers are low.

Top module: `tapctl_top`

## Requirements
- R1: After reset, `busy`, `ack` and `err` are 0, `rdata` is 0 and `reg_q` is all zeros.
- R2: While `busy` is 1, `cmd_valid` is ignored. A command is taken on a clock edge where `cmd_valid` is 1 and `busy` is 0. From that edge `busy` stays 1 until `ack` rises, which is 2 edges later for every opcode except erase. `ack` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R3: Preload (opcode 0) sets `reg_q[cmd_addr]` to `cmd_data[0]` one edge after the command is taken. On that edge the preload wins over capture for the target bit only.
- R4: On any edge where a bit is not being preloaded and `cap_en` is 1, that bit of `reg_q` takes the matching bit of `cap_d`. When `cap_en` is 0, the bit holds.
- R5: Fuse program (opcode 1) stores `cmd_data` at fuse word `cmd_addr`. Fuse verify (opcode 2) returns that word in `rdata` with `err` 0.
- R6: Signature write (opcode 3) and read (opcode 4) address byte `cmd_addr[2:0]`. The upper address bits are ignored.
- R7: Set-security (opcode 5) takes effect for the very next command. From then on, opcodes 0, 1 and 2 complete with `err` 1 and `rdata` 0, and they change neither `reg_q` nor any fuse word.
- R8: Signature write and read behave the same whether or not the security bit is set.
- R9: Full erase (opcode 6) acknowledges FUSE_DEPTH+2 edges after it is taken. It clears every fuse word to zero and clears the security bit, and it keeps the signature bytes.
- R10: Preload with `cmd_addr` >= NREG, and opcode 7, complete with `err` 1 and `rdata` 0 and change nothing.
- R11: Accepted commands other than verify and signature read complete with `err` 0 and `rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | $clog2(FUSE_DEPTH) | Fuse word, register index or signature byte |
| cmd_data | input | DW | Write data; bit 0 is the preload level |
| busy | output | 1 | Command in progress |
| ack | output | 1 | One-cycle completion strobe |
| err | output | 1 | Command refused, valid with ack |
| rdata | output | DW | Read data, valid with ack |
| cap_en | input | 1 | Capture enable for the output registers |
| cap_d | input | NREG | Next state from the logic array |
| reg_q | output | NREG | Output register bank |

## Verification
Fuse words are programmed at the lowest address, a middle address and the highest address. They are then read back along with untouched words, which separates correct addressing from a write that lands everywhere or nowhere. Signature bytes are read through addresses whose upper bits are set, which exposes any decode that uses more than three bits. Preloads of both levels go to every register while capture toggles at random; this separates target-only priority from a preload that blocks the whole bank. The same commands are then repeated after locking and again after erase, which separates the commands that are locked from the ones that are open, and shows whether erase clears the lock and the fuses while the signature survives.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;

  typedef enum logic [2:0] {
    OP_PRELOAD = 3'd0,
    OP_FPROG   = 3'd1,
    OP_FVERIFY = 3'd2,
    OP_SIGWR   = 3'd3,
    OP_SIGRD   = 3'd4,
    OP_SECURE  = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } tap_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_ERASE,
    ST_RESP
  } tap_st_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_FUSE,
    SRC_SIG
  } tap_src_e;

endpackage

// File: rtl/tapctl_ram.sv
module tapctl_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  // single write port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/tapctl_regbank.sv
module tapctl_regbank #(
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic [NREG-1:0] cap_d,
  input  logic            pl_we,
  input  logic [RW-1:0]   pl_idx,
  input  logic            pl_val,
  output logic [NREG-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (pl_we && pl_idx == RW'(i)) q[i] <= pl_val;
        else if (cap_en)               q[i] <= cap_d[i];
      end
    end
  end

  // R3: a preload lands on its target register one edge later
  a_r3_preload_lands: assert property (@(posedge clk) disable iff (rst)
    pl_we |=> q[$past(pl_idx)] == $past(pl_val));

endmodule

// File: rtl/tapctl_top.sv
module tapctl_top
  import tapctl_pkg::*;
#(
  parameter int NREG       = 8,
  parameter int FUSE_DEPTH = 32,
  parameter int DW         = 8,
  parameter int SIG_BYTES  = 8,
  localparam int AW        = $clog2(FUSE_DEPTH),
  localparam int SW        = $clog2(SIG_BYTES),
  localparam int RW        = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  output logic            busy,
  output logic            ack,
  output logic            err,
  output logic [DW-1:0]   rdata,
  input  logic            cap_en,
  input  logic [NREG-1:0] cap_d,
  output logic [NREG-1:0] reg_q
);

  tap_st_e       st;
  tap_op_e       op_q;
  tap_src_e      src_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] er_cnt;
  logic [DW-1:0] data_q;
  logic          secure;
  logic          err_q;

  logic          refuse;
  logic          f_we, s_we, pl_we;
  logic [AW-1:0] f_wa;
  logic [DW-1:0] f_wd, f_rd, s_rd;

  // decision made in the execute cycle against the current lock state
  always_comb begin
    refuse = ((op_q == OP_PRELOAD || op_q == OP_FPROG || op_q == OP_FVERIFY) && secure)
           || (op_q == OP_PRELOAD && {{(32-AW){1'b0}}, addr_q} >= 32'(NREG))
           || (op_q == OP_RSVD);
    f_we  = (st == ST_EXEC && op_q == OP_FPROG && !refuse) || (st == ST_ERASE);
    f_wa  = (st == ST_ERASE) ? er_cnt : addr_q;
    f_wd  = (st == ST_ERASE) ? '0 : data_q;
    s_we  = (st == ST_EXEC && op_q == OP_SIGWR);
    pl_we = (st == ST_EXEC && op_q == OP_PRELOAD && !refuse);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      op_q   <= OP_PRELOAD;
      src_q  <= SRC_NONE;
      addr_q <= '0;
      data_q <= '0;
      er_cnt <= '0;
      secure <= 1'b0;
      err_q  <= 1'b0;
      busy   <= 1'b0;
      ack    <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= tap_op_e'(cmd_op);
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            busy   <= 1'b1;
            st     <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          err_q <= refuse;
          if (refuse)                  src_q <= SRC_NONE;
          else if (op_q == OP_FVERIFY) src_q <= SRC_FUSE;
          else if (op_q == OP_SIGRD)   src_q <= SRC_SIG;
          else                         src_q <= SRC_NONE;
          if (op_q == OP_SECURE) secure <= 1'b1;
          if (op_q == OP_ERASE) begin
            er_cnt <= '0;
            st     <= ST_ERASE;
          end else begin
            st <= ST_RESP;
          end
        end
        ST_ERASE: begin
          er_cnt <= er_cnt + 1'b1;
          if (er_cnt == AW'(FUSE_DEPTH - 1)) st <= ST_RESP;
        end
        default: begin
          ack  <= 1'b1;
          busy <= 1'b0;
          err  <= err_q;
          case (src_q)
            SRC_FUSE: rdata <= f_rd;
            SRC_SIG:  rdata <= s_rd;
            default:  rdata <= '0;
          endcase
          if (op_q == OP_ERASE) secure <= 1'b0;
          st <= ST_IDLE;
        end
      endcase
    end
  end

  tapctl_ram #(.DEPTH(FUSE_DEPTH), .W(DW)) u_fuse (
    .clk(clk), .we(f_we), .wa(f_wa), .wd(f_wd), .ra(addr_q), .rd(f_rd)
  );

  tapctl_ram #(.DEPTH(SIG_BYTES), .W(DW)) u_sig (
    .clk(clk), .we(s_we), .wa(addr_q[SW-1:0]), .wd(data_q),
    .ra(addr_q[SW-1:0]), .rd(s_rd)
  );

  tapctl_regbank #(.NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_d(cap_d),
    .pl_we(pl_we), .pl_idx(addr_q[RW-1:0]), .pl_val(data_q[0]), .q(reg_q)
  );

  // R2: completion strobe lasts one cycle
  a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R2: port is free again when the strobe shows
  a_r2_ack_idle: assert property (@(posedge clk) disable iff (rst)
    ack |-> !busy);

  // R2: every command occupies at least two cycles
  a_r2_busy_min: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  // R7, R10: refused commands leak no data
  a_r7_refuse_zero: assert property (@(posedge clk) disable iff (rst)
    (ack && err) |-> rdata == '0);

  // R9: the lock is only released by an erase
  a_r9_unlock_by_erase: assert property (@(posedge clk) disable iff (rst)
    $fell(secure) |-> $past(op_q) == OP_ERASE);

endmodule

// File: tb/tapctl_top_bench.sv
module tapctl_top_bench;

  localparam int NREG = 8;
  localparam int FD   = 32;
  localparam int DW   = 8;
  localparam int AW   = $clog2(FD);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [2:0]      cmd_op = '0;
  logic [AW-1:0]   cmd_addr = '0;
  logic [DW-1:0]   cmd_data = '0;
  logic            busy, ack, err;
  logic [DW-1:0]   rdata;
  logic            cap_en = 1'b0;
  logic [NREG-1:0] cap_d = '0;
  logic [NREG-1:0] reg_q;
  bit              cap_on = 1'b0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  tapctl_top #(.NREG(NREG), .FUSE_DEPTH(FD), .DW(DW), .SIG_BYTES(8)) u_tapctl_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .ack(ack),
    .err(err), .rdata(rdata), .cap_en(cap_en), .cap_d(cap_d), .reg_q(reg_q)
  );

  always #10 clk = ~clk;  // 50 MHz

  // ---------------- behavioural reference model ----------------
  bit              m_busy, m_ack, m_err, m_sec, m_ref, pl_hit;
  logic [DW-1:0]   m_rdata;
  logic [NREG-1:0] m_q;
  logic [DW-1:0]   m_fuse [FD];
  logic [DW-1:0]   m_sig  [8];
  int              m_step, m_len, p_op, p_addr, pl_i;
  logic [DW-1:0]   p_data;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_ack = 0; m_err = 0; m_sec = 0; m_rdata = '0; m_q = '0;
    end else begin
      pl_hit = 0;
      m_ack  = 0;
      if (m_busy) begin
        m_step++;
        if (m_step == 1) begin
          m_ref = ((p_op <= 2) && m_sec) || (p_op == 0 && p_addr >= NREG) || (p_op == 7);
          if (p_op == 0 && !m_ref) begin pl_hit = 1; pl_i = p_addr; end
        end
        if (m_step == m_len) begin
          m_ack = 1; m_busy = 0; m_err = m_ref; m_rdata = '0;
          if (!m_ref) begin
            case (p_op)
              1: m_fuse[p_addr] = p_data;
              2: m_rdata = m_fuse[p_addr];
              3: m_sig[p_addr % 8] = p_data;
              4: m_rdata = m_sig[p_addr % 8];
              5: m_sec = 1;
              6: begin
                for (int k = 0; k < FD; k++) m_fuse[k] = '0;
                m_sec = 0;
              end
              default: ;
            endcase
          end
        end
      end else if (cmd_valid) begin
        p_op = int'(cmd_op); p_addr = int'(cmd_addr); p_data = cmd_data;
        m_busy = 1; m_step = 0;
        m_len = (p_op == 6) ? FD + 2 : 2;
      end
      for (int i = 0; i < NREG; i++) begin
        if (pl_hit && pl_i == i) m_q[i] = p_data[0];
        else if (cap_en)         m_q[i] = cap_d[i];
      end
    end
  end

  function automatic string tag_of(int op, bit refd);
    if (refd)                return (op == 7 || (op == 0 && m_sec == 0)) ? "R10" : "R7";
    if (op == 1 || op == 2)  return "R5";
    if (op == 3 || op == 4)  return m_sec ? "R8" : "R6";
    if (op == 6)             return "R9";
    if (op == 0)             return "R3";
    return "R11";
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2", "busy", busy, m_busy);
      check("R2", "ack", ack, m_ack);
      check("R4", "reg_q", reg_q, m_q);
      if (m_ack) begin
        check(tag_of(p_op, m_ref), "err", err, m_err);
        check(m_ref ? "R7" : "R11", "rdata", rdata, m_rdata);
      end
    end
  end

  // capture traffic from the logic array
  always @(negedge clk) begin
    cap_d  <= NREG'($urandom);
    cap_en <= cap_on && ($urandom % 2 == 1);
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cmd(input int op, input int addr, input int data, input bit stray = 0);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_addr  = AW'(addr);
    cmd_data  = DW'(data);
    @(negedge clk);
    if (stray) begin
      // R2: request held while busy must be ignored
      cmd_op = 3'd0; cmd_addr = '0; cmd_data = 8'h01;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (!ack) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "busy", busy, 0);
    check("R1", "ack", ack, 0);
    check("R1", "err", err, 0);
    check("R1", "rdata", rdata, 0);
    check("R1", "reg_q", reg_q, 0);

    cap_on = 1'b1;              // R4 capture runs throughout
    repeat (10) @(negedge clk);

    cmd(6, 0, 0);               // R9 erase to known state
    cmd(2, 3, 0);               // R5 blank word reads zero
    cmd(1, 0, 8'hA5);           // R5 low, middle, top
    cmd(1, 17, 8'h3C);
    cmd(1, 31, 8'hFF, 1);       // R2 stray request while busy
    cmd(2, 0, 0);
    cmd(2, 17, 0);
    cmd(2, 31, 0);
    cmd(2, 16, 0);

    for (int i = 0; i < 8; i++) cmd(3, i, 8'h11 * (i + 1));  // R6
    for (int i = 0; i < 8; i++) cmd(4, 8 + i, 0);            // R6 upper bits ignored
    cmd(3, 24 + 5, 8'h9E);      // R6 writes byte 5
    cmd(4, 5, 0);

    for (int i = 0; i < NREG; i++) begin                      // R3
      cmd(0, i, 1);
      cmd(0, i, 0);
    end
    cmd(0, 9, 1);               // R10 index out of range
    cmd(7, 0, 0);               // R10 reserved opcode

    cap_on = 1'b0;
    repeat (3) @(negedge clk);
    cmd(5, 0, 0);               // R7 lock
    cmd(2, 17, 0);              // R7 verify refused
    cmd(1, 17, 8'h00);          // R7 program refused
    cmd(0, 2, 1);               // R7 preload refused, reg_q held
    cmd(0, 3, 0);
    cmd(4, 2, 0);               // R8 signature still open
    cmd(3, 6, 8'h42);
    cmd(4, 6, 0);
    cap_on = 1'b1;

    cmd(6, 0, 0, 1);            // R9 erase releases lock
    cmd(2, 17, 0);              // R9 fuse cleared
    cmd(2, 0, 0);
    cmd(4, 6, 0);               // R9 signature kept
    cmd(4, 0, 0);
    cmd(0, 4, 1);               // R9 preload allowed again
    cmd(1, 9, 8'h77);
    cmd(2, 9, 0);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule